// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the clock line timing for an I2C bus master. A byte engine asks for bit clocks with a `run` request. The generator then drives SCL low and releases it in turn. The length of each low and high phase comes from two 5-bit count registers and a 3-bit power-of-two prescaler. It also gives the byte engine a one-cycle tick at each SCL edge. The rising-edge tick is the point to sample SDA, and the falling-edge tick is the point to change it.

The observed SCL line first passes through a two-flop synchroniser and a glitch filter that needs two equal samples. The high phase is not counted until that conditioned line reads high, so a slave that holds SCL low lengthens the bit. Every phase also contains a fixed number of internal cycles on top of the register value: four reference cycles when the prescaler is bypassed, three prescaled cycles otherwise.

The configuration registers sit on a small write/read port. The prescaler field can only be changed by a write that also sets a write-protect release bit. The generator stays idle with SCL released whenever the controller is disabled or held in reset.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset SCL is released and both ticks are low. The mode register reads 0x00, and both count registers read 0xFF, which is a count value of 31.
- R2: Register addresses are fixed. Address 0 is the mode register, with the divider select in bits 6:4 and all other bits reading 0. Address 1 is the low count and address 2 is the high count, each holding its value in bits 4:0 and reading bits 7:5 as 1. Address 3 reads 0.
- R3: Writing a count of 0 to either count register stores 1, because 1 is the minimum legal count.
- R4: A write to address 0 updates the divider select only when bit 3 of the same write data is 1. Otherwise the mode register is left unchanged.
- R5: Let D = 2^CKS, and let OV = 4 when CKS = 0 and OV = 3 otherwise. Each low phase drives SCL low for exactly (L+OV)·D clock cycles.
- R6: The high count starts three clock edges after the first edge that samples `scl_in` high. SCL then stays released for (H+OV)·D further cycles. Any time a slave holds SCL low adds to the released time cycle for cycle.
- R7: A high pulse on `scl_in` that lasts one clock cycle is ignored and does not start the high count.
- R8: `tick_fall` is high for one cycle, in the first cycle of every low phase. `tick_rise` is high for one cycle, in the cycle after the high count starts. The two ticks are never high together.
- R9: From idle, `run` = 1 starts a low phase. If `run` is 0 at the end of a high phase, SCL stays released, the block returns to idle, and no `tick_fall` is produced.
- R10: `ctl_enable` = 0 or `ctl_reset` = 1 sends the generator to idle on the next cycle, with SCL released and no ticks. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable |
| ctl_reset | input | 1 | Controller internal reset hold |
| run | input | 1 | Request to keep generating bit clocks |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| scl_in | input | 1 | Observed SCL bus line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| tick_rise | output | 1 | One-cycle pulse after SCL is seen high |
| tick_fall | output | 1 | One-cycle pulse when SCL is pulled low |

## Verification
The in-design assertions check the following on every cycle:
- the ticks never overlap, and `tick_fall` coincides with SCL being driven;
- `tick_rise` follows a conditioned high on the line;
- the count registers never hold zero;
- a mode write without the release bit leaves the divider unchanged;
- the phase counter never passes its target;
- the block falls silent one cycle after being disabled.

The exact phase lengths for different divider and count settings can only be shown by the bench scenarios, which measure runs of the SCL drive. The same holds for the extra released time caused by a stretching slave, the rejection of a one-cycle glitch, and the clean stop when `run` falls.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CKS_W      = 3,
  parameter int CNT_W      = 5,
  parameter int REG_W      = 8,
  parameter int CKS_LSB    = 4,
  parameter int WP_BIT     = 3,
  parameter int OVH_DIRECT = 4,
  parameter int OVH_SCALED = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             ctl_reset,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             tick_rise,
  output logic             tick_fall
);

  localparam int PRE_W = (1 << CKS_W) - 1;
  localparam int PH_W  = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HWAIT, S_HIGH} phase_e;

  phase_e             state_q, state_d;
  logic [CKS_W-1:0]   cks_q;
  logic [CNT_W-1:0]   low_q, high_q;
  logic [PRE_W-1:0]   pre_q, div_m1;
  logic [PH_W-1:0]    cnt_q, n_tgt, ovh;
  logic               s1_q, s2_q, scl_f;
  logic               active, pre_last, last_tick, enter_low, enter_high;
  logic               unused_wdata;

  assign active = ctl_enable && !ctl_reset;
  assign unused_wdata = ^{cfg_wdata[REG_W-1], cfg_wdata[WP_BIT-1:0]};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cks_q  <= '0;
      low_q  <= CNT_MAX;
      high_q <= CNT_MAX;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: if (cfg_wdata[WP_BIT]) cks_q <= cfg_wdata[CKS_LSB +: CKS_W];
        2'd1: low_q  <= (cfg_wdata[CNT_W-1:0] == '0) ? CNT_MIN : cfg_wdata[CNT_W-1:0];
        2'd2: high_q <= (cfg_wdata[CNT_W-1:0] == '0) ? CNT_MIN : cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0: cfg_rdata[CKS_LSB +: CKS_W] = cks_q;
      2'd1: cfg_rdata = {{(REG_W-CNT_W){1'b1}}, low_q};
      2'd2: cfg_rdata = {{(REG_W-CNT_W){1'b1}}, high_q};
      default: cfg_rdata = '0;
    endcase
  end

  // line synchroniser with two-sample agreement filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      scl_f <= 1'b1;
    end else begin
      s1_q <= scl_in;
      s2_q <= s1_q;
      if (s1_q == s2_q) scl_f <= s2_q;
    end
  end

  // prescaler and phase counting
  assign div_m1    = ({{(PRE_W-1){1'b0}}, 1'b1} << cks_q) - 1'b1;
  assign pre_last  = (pre_q == div_m1);
  assign ovh       = (cks_q == '0) ? PH_W'(OVH_DIRECT) : PH_W'(OVH_SCALED);
  assign n_tgt     = {1'b0, (state_q == S_LOW) ? low_q : high_q} + ovh;
  assign last_tick = pre_last && (cnt_q == n_tgt - 1'b1);

  always_comb begin
    state_d = state_q;
    if (!active) state_d = S_IDLE;
    else begin
      case (state_q)
        S_IDLE:  if (run) state_d = S_LOW;
        S_LOW:   if (last_tick) state_d = S_HWAIT;
        S_HWAIT: if (scl_f) state_d = S_HIGH;
        S_HIGH:  if (last_tick) state_d = run ? S_LOW : S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign enter_low  = (state_d == S_LOW)  && (state_q != S_LOW);
  assign enter_high = (state_d == S_HIGH) && (state_q != S_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pre_q     <= '0;
      cnt_q     <= '0;
      tick_rise <= 1'b0;
      tick_fall <= 1'b0;
    end else begin
      state_q   <= state_d;
      tick_fall <= enter_low;
      tick_rise <= enter_high;
      if (enter_low || enter_high) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (state_q == S_LOW || state_q == S_HIGH) begin
        pre_q <= pre_last ? '0 : pre_q + 1'b1;
        if (pre_last) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign scl_drive_low = (state_q == S_LOW);

  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_rise && tick_fall)); // R8
  AST_FALL_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_drive_low); // R8
  AST_RISE_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> $past(scl_f)); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!scl_drive_low && !tick_rise && !tick_fall)); // R10
  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q != '0) && (high_q != '0)); // R3
  AST_CKS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0 && !cfg_wdata[WP_BIT]) |=> $stable(cks_q)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOW || state_q == S_HIGH) |-> (cnt_q < n_tgt)); // R5

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic clk = 0, rst_n = 0, ctl_enable = 0, ctl_reset = 0, run = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata, rv;
  logic scl_r = 1;
  logic scl_drive_low, tick_rise, tick_fall;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_reset(ctl_reset),
    .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .scl_in(scl_r), .scl_drive_low(scl_drive_low),
    .tick_rise(tick_rise), .tick_fall(tick_fall));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_len(int cks, int l);
    return (l + ((cks == 0) ? 4 : 3)) * (1 << cks);
  endfunction
  function automatic int high_len(int cks, int h, int held);
    return held + 4 + (h + ((cks == 0) ? 4 : 3)) * (1 << cks);
  endfunction

  // bench model of the bus line plus phase measurement
  bit mon_on = 0;
  int e_cks, e_l, e_h;
  int n_low, lo_cnt, hi_cnt, rel_idx, stretch, last_low, rise_idx;
  bit prev_low, have_high, glitch, sv;

  always @(negedge clk) begin
    if (!mon_on) begin
      prev_low = 0; have_high = 0; n_low = 0;
      scl_r = !scl_drive_low;
    end else if (scl_drive_low) begin
      if (!prev_low) begin
        if (have_high) begin
          chk(hi_cnt == high_len(e_cks, e_h, last_low), glitch ? "R7 glitch" : "R6 high",
              hi_cnt, high_len(e_cks, e_h, last_low));
          chk(rise_idx == last_low + 5, "R8 rise tick", rise_idx, last_low + 5);
        end
        chk(tick_fall == 1, "R8 fall tick", tick_fall, 1);
        lo_cnt = 0;
        n_low++;
      end
      lo_cnt++;
      scl_r = 0;
      prev_low = 1;
    end else begin
      if (prev_low) begin
        chk(lo_cnt == low_len(e_cks, e_l), "R5 low", lo_cnt, low_len(e_cks, e_l));
        hi_cnt = 0; rel_idx = 0; last_low = 0; rise_idx = 0;
        stretch = $urandom_range(0, 12);
        glitch = (stretch >= 4) && ($urandom_range(0, 1) == 1);
        have_high = 1;
      end
      rel_idx++; hi_cnt++;
      if (tick_fall) chk(0, "R8 fall while released", 1, 0);
      sv = rel_idx > stretch;
      if (glitch && rel_idx == 2) sv = 1;
      if (!sv) last_low = rel_idx;
      if (tick_rise && rise_idx == 0) rise_idx = hi_cnt;
      scl_r = sv;
      prev_low = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic run_cfg(input int c, input int l, input int h);
    int base;
    wr(2'd0, 8'(8'h08 | (c << 4)));
    wr(2'd1, 8'(l));
    wr(2'd2, 8'(h));
    e_cks = c; e_l = l; e_h = h;
    @(negedge clk); mon_on = 1; run = 1;
    while (n_low < 4) @(negedge clk);
    run = 0;
    @(negedge clk); #1 base = n_low;
    repeat (700) @(negedge clk);
    chk(n_low == base, "R9 stop no new low", n_low, base);
    chk(scl_drive_low == 0, "R9 released", scl_drive_low, 0);
    mon_on = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(scl_drive_low == 0 && tick_rise == 0 && tick_fall == 0, "R1 outputs", scl_drive_low, 0);
    rst_n = 1; ctl_enable = 1;
    rd(2'd0, rv); chk(rv == 8'h00, "R1 mode", rv, 8'h00);
    rd(2'd1, rv); chk(rv == 8'hFF, "R1 low", rv, 8'hFF);
    rd(2'd2, rv); chk(rv == 8'hFF, "R1 high", rv, 8'hFF);
    wr(2'd0, 8'h70); rd(2'd0, rv); chk(rv == 8'h00, "R4 protected", rv, 8'h00);
    wr(2'd0, 8'h28); rd(2'd0, rv); chk(rv == 8'h20, "R4 released", rv, 8'h20);
    wr(2'd0, 8'h57); rd(2'd0, rv); chk(rv == 8'h20, "R4 bit3 clear", rv, 8'h20);
    wr(2'd1, 8'h00); rd(2'd1, rv); chk(rv == 8'hE1, "R3 low zero", rv, 8'hE1);
    wr(2'd2, 8'h00); rd(2'd2, rv); chk(rv == 8'hE1, "R3 high zero", rv, 8'hE1);
    wr(2'd2, 8'h05); rd(2'd2, rv); chk(rv == 8'hE5, "R2 high", rv, 8'hE5);
    wr(2'd1, 8'h1F); rd(2'd1, rv); chk(rv == 8'hFF, "R2 low", rv, 8'hFF);
    rd(2'd3, rv); chk(rv == 8'h00, "R2 addr3", rv, 8'h00);

    run_cfg(0, 1, 1);
    run_cfg(3, 31, 31);
    run_cfg(1, 2, 9);
    for (int i = 0; i < 8; i++)
      run_cfg($urandom_range(0, 3), $urandom_range(1, 31), $urandom_range(1, 31));

    // R10: disable and reset hold
    wr(2'd1, 8'h0C);
    for (int k = 0; k < 2; k++) begin
      run = 1;
      while (!scl_drive_low) @(negedge clk);
      repeat (3) @(negedge clk);
      if (k == 0) ctl_enable = 0; else ctl_reset = 1;
      @(negedge clk);
      for (int j = 0; j < 20; j++) begin
        #1;
        if (scl_drive_low || tick_rise || tick_fall)
          chk(0, "R10 idle", 1, 0);
        @(negedge clk);
      end
      chk(scl_drive_low == 0, "R10 released", scl_drive_low, 0);
      run = 0;
      ctl_enable = 1; ctl_reset = 0;
      rd(2'd1, rv); chk(rv == 8'hEC, "R10 regs kept", rv, 8'hEC);
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule